// File: doc/BRIEF.md
# Grouped Masked Interrupt Aggregator

The block collects change events from a set of monitored status lines and turns them into two interrupt outputs for a microprocessor. Each status line has a sticky change bit, called a delta. The delta sets on either edge of the line and stays set until software clears it. Every delta has its own mask bit. The deltas fall into four groups. A group's summary bit is set while any delta in that group is set and unmasked.

A second level combines the groups. Each group has a group-enable mask, and the global summary bit is set while any unmasked group summary is set. A summary mask gates the global summary onto the active-low interrupt pin. A separate bank of receive protection-switching deltas works the same way. Its own per-bit masks gate it onto a second active-low pin.

The masks act only on the pins. The global summary bit and the protection summary bit can always be read, so software can run the block interrupt-driven or polled. After an interrupt, software reads the summary word to find the active groups. It then reads those groups' delta words to find the cause.

Top module: `intr_aggregator`

## Requirements
- R1: After reset, all delta bits read 0 and both interrupt outputs are 1 (inactive). Every mask bit reads 1: the per-source masks, the protection masks, and control bits [4:0] (group masks [3:0] and summary mask [4]).
- R2: A delta bit is set one clock after its status input has a rising or a falling edge. It stays set until software clears it.
- R3: Writing to a delta word (address 0 to 3 for groups 0 to 3, address 8 for the protection bank) clears each delta bit whose data bit is 1. Data bits of 0 leave their delta unchanged. An edge on a bit in the same cycle as its clear leaves the bit set.
- R4: The mask words can be written and read back. Addresses 4 to 7 hold the per-source masks of groups 0 to 3, address 9 the protection masks, and address 10 the control word. Bits above a word's width read 0.
- R5: Summary word (address 11) bit g, for g from 0 to 3, is 1 exactly when group g holds a delta that is set and whose per-source mask is 0.
- R6: Summary word bit 4 is 1 exactly when some group has summary bit 1 and group mask 0. The summary mask has no effect on this bit.
- R7: The output int_n_o is 0 exactly one clock after a cycle in which summary bit 4 is 1 and the summary mask is 0. Otherwise it is 1, so with the summary mask at 1 it stays 1 (polled operation).
- R8: Summary word bit 5 is 1 while any protection delta is set, whatever the protection masks hold. The output aps_int_n_o is 0 exactly one clock after a cycle in which some protection delta is set with its mask at 0.
- R9: Writes to the summary word and to addresses 12 to 15 change no state. Reads of addresses 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovh_stat_i | input | G0_W | Group 0 (overhead) status lines |
| ptr_stat_i | input | G1_W | Group 1 (pointer) status lines |
| path_stat_i | input | G2_W | Group 2 (path) status lines |
| aux_stat_i | input | G3_W | Group 3 (auxiliary) status lines |
| aps_stat_i | input | APS_W | Receive protection-switching status lines |
| reg_wr_i | input | 1 | Register write strobe for this cycle |
| reg_addr_i | input | 4 | Register address for read and write |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i, combinational |
| int_n_o | output | 1 | Active-low summary interrupt |
| aps_int_n_o | output | 1 | Active-low protection interrupt |

## Verification
The bench builds the block with its default widths: nine, two, six and three sources in the four groups, two protection sources, and a 16-bit data word. With these values, padding bits above every field and the four unmapped addresses can be reached. With 22 sources against 16 address values, random writes often land on a live clear or mask while status lines keep toggling. The same-cycle edge and clear case, and the rule that masks touch only the pins, then come up both by direction and at random.

// File: rtl/intr_agg_pkg.sv
// Package: register addresses and sizing helpers shared by the aggregator.
// Assumes a 4-bit register address and exactly four source groups.
package intr_agg_pkg;
    localparam int ADDR_W = 4;
    localparam int NGRP   = 4;
    localparam int NBANK  = NGRP + 1;

    localparam logic [ADDR_W-1:0] A_DLT_BASE = 4'd0;
    localparam logic [ADDR_W-1:0] A_MSK_BASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_APS_DLT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_APS_MSK  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd10;
    localparam logic [ADDR_W-1:0] A_SUM      = 4'd11;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/intr_delta_bank.sv
// Delta bank: edge-captured sticky change bits with write-one-to-clear and
// a per-bit mask that resets to all ones. Assumes W <= data width at parent.
module intr_delta_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic         clr_we_i,
    input  logic         msk_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] delta_o,
    output logic [W-1:0] mask_o,
    output logic         hit_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] delta_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] edge_v;
    logic [W-1:0] clr_v;

    assign edge_v = stat_i ^ prev_q;
    assign clr_v  = clr_we_i ? wdata_i : '0;

    // Previous status sample; tracks the input during reset so no false edge.
    always_ff @(posedge clk) begin
        prev_q <= stat_i;
    end

    // Sticky delta: clear by write-one, a simultaneous edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) delta_q <= '0;
        else        delta_q <= (delta_q & ~clr_v) | edge_v;
    end

    // Per-source mask, masked by default.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (msk_we_i) mask_q <= wdata_i;
    end

    assign delta_o = delta_q;
    assign mask_o  = mask_q;
    assign hit_o   = |(delta_q & ~mask_q);
endmodule

// File: rtl/intr_summary.sv
// Summary stage: forms the global summary from group hits and group masks,
// and registers both active-low interrupt pins. Masks gate pins only.
module intr_summary #(
    parameter int NG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] grp_hit_i,
    input  logic [NG-1:0] grp_mask_i,
    input  logic          sum_mask_i,
    input  logic          aps_hit_i,
    output logic          sum_int_o,
    output logic          int_n_o,
    output logic          aps_int_n_o
);
    logic int_n_q;
    logic aps_n_q;

    assign sum_int_o = |(grp_hit_i & ~grp_mask_i);

    // Registered pins, inactive high out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_n_q <= 1'b1;
            aps_n_q <= 1'b1;
        end else begin
            int_n_q <= !(sum_int_o && !sum_mask_i);
            aps_n_q <= !aps_hit_i;
        end
    end

    assign int_n_o     = int_n_q;
    assign aps_int_n_o = aps_n_q;
endmodule

// File: rtl/intr_readmux.sv
// Read multiplexer: selects a zero-padded register word by address.
// Unmapped addresses return zero. Assumes the address map in the package.
module intr_readmux
    import intr_agg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     dlt_i [NBANK],
    input  logic [DW-1:0]     msk_i [NBANK],
    input  logic [DW-1:0]     ctrl_i,
    input  logic [DW-1:0]     sum_i,
    output logic [DW-1:0]     rdata_o
);
    // Address decode for reads.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_DLT_BASE, 4'd1, 4'd2, 4'd3: rdata_o = dlt_i[addr_i[1:0]];
            A_MSK_BASE, 4'd5, 4'd6, 4'd7: rdata_o = msk_i[addr_i[1:0]];
            A_APS_DLT:                    rdata_o = dlt_i[NGRP];
            A_APS_MSK:                    rdata_o = msk_i[NGRP];
            A_CTRL:                       rdata_o = ctrl_i;
            A_SUM:                        rdata_o = sum_i;
            default:                      rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/intr_aggregator.sv
// Top: four source groups plus a protection bank, each a delta bank, feeding
// a two-level summary and two active-low interrupt pins. Control word holds
// group masks [NGRP-1:0] and summary mask [NGRP]; all reset to one.
module intr_aggregator
    import intr_agg_pkg::*;
#(
    parameter int G0_W  = 9,
    parameter int G1_W  = 2,
    parameter int G2_W  = 6,
    parameter int G3_W  = 3,
    parameter int APS_W = 2,
    parameter int DW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [G0_W-1:0]   ovh_stat_i,
    input  logic [G1_W-1:0]   ptr_stat_i,
    input  logic [G2_W-1:0]   path_stat_i,
    input  logic [G3_W-1:0]   aux_stat_i,
    input  logic [APS_W-1:0]  aps_stat_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              int_n_o,
    output logic              aps_int_n_o
);
    localparam int BW   [NBANK] = '{G0_W, G1_W, G2_W, G3_W, APS_W};
    localparam int BOFF [NBANK] = '{0, G0_W, G0_W + G1_W, G0_W + G1_W + G2_W,
                                    G0_W + G1_W + G2_W + G3_W};
    localparam int TOT_W = G0_W + G1_W + G2_W + G3_W + APS_W;
    localparam int WMAX  = imax(imax(imax(G0_W, G1_W), imax(G2_W, G3_W)),
                                imax(APS_W, NGRP + 1));

    logic [TOT_W-1:0] stat_all;
    logic [TOT_W-1:0] delta_all;
    logic [NBANK-1:0] hit_v;
    logic [DW-1:0]    dlt_pad [NBANK];
    logic [DW-1:0]    msk_pad [NBANK];
    logic [NGRP:0]    ctrl_q;
    logic [APS_W-1:0] aps_mask;
    logic             aps_any;
    logic             sum_int;

    assign stat_all = {aps_stat_i, aux_stat_i, path_stat_i, ptr_stat_i, ovh_stat_i};

    // One delta bank per group, the last one for the protection sources.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] DA = (b < NGRP) ? ADDR_W'(int'(A_DLT_BASE) + b) : A_APS_DLT;
        localparam logic [ADDR_W-1:0] MA = (b < NGRP) ? ADDR_W'(int'(A_MSK_BASE) + b) : A_APS_MSK;
        logic [BW[b]-1:0] dlt;
        logic [BW[b]-1:0] msk;

        intr_delta_bank #(.W(BW[b])) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .stat_i   (stat_all[BOFF[b] +: BW[b]]),
            .clr_we_i (reg_wr_i && (reg_addr_i == DA)),
            .msk_we_i (reg_wr_i && (reg_addr_i == MA)),
            .wdata_i  (reg_wdata_i[BW[b]-1:0]),
            .delta_o  (dlt),
            .mask_o   (msk),
            .hit_o    (hit_v[b])
        );

        assign delta_all[BOFF[b] +: BW[b]] = dlt;
        assign dlt_pad[b] = DW'(dlt);
        assign msk_pad[b] = DW'(msk);
    end

    if (DW > WMAX) begin : g_pad
        logic unused_wdata;
        assign unused_wdata = ^reg_wdata_i[DW-1:WMAX];
    end

    assign aps_mask = g_bank[NGRP].msk;
    assign aps_any  = |delta_all[TOT_W-1 -: APS_W];

    // Control word: group masks and summary mask, masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ctrl_q <= '1;
        else if (reg_wr_i && (reg_addr_i == A_CTRL)) ctrl_q <= reg_wdata_i[NGRP:0];
    end

    intr_summary #(.NG(NGRP)) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_hit_i   (hit_v[NGRP-1:0]),
        .grp_mask_i  (ctrl_q[NGRP-1:0]),
        .sum_mask_i  (ctrl_q[NGRP]),
        .aps_hit_i   (hit_v[NGRP]),
        .sum_int_o   (sum_int),
        .int_n_o     (int_n_o),
        .aps_int_n_o (aps_int_n_o)
    );

    intr_readmux #(.DW(DW)) u_rd (
        .addr_i  (reg_addr_i),
        .dlt_i   (dlt_pad),
        .msk_i   (msk_pad),
        .ctrl_i  (DW'(ctrl_q)),
        .sum_i   (DW'({aps_any, sum_int, hit_v[NGRP-1:0]})),
        .rdata_o (reg_rdata_o)
    );
endmodule

// File: rtl/intr_aggregator_chk.sv
// Checker: temporal properties of the aggregator pins and delta capture.
// Assumes the protection deltas sit at the top of the flat delta vector.
module intr_aggregator_chk #(
    parameter int TOT_W = 22,
    parameter int APS_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TOT_W-1:0] stat_all,
    input logic [TOT_W-1:0] delta_all,
    input logic             sum_int,
    input logic             sum_mask,
    input logic [APS_W-1:0] aps_mask,
    input logic             int_n_o,
    input logic             aps_int_n_o
);
    logic [TOT_W-1:0] stat_q;
    logic [TOT_W-1:0] chg_q;

    // Independent edge record of the status inputs.
    always_ff @(posedge clk) begin
        stat_q <= stat_all;
        if (!rst_n) chg_q <= '0;
        else        chg_q <= stat_all ^ stat_q;
    end

    AST_RESET_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> (int_n_o && aps_int_n_o)); // R1
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (delta_all & chg_q) == chg_q); // R2
    AST_INT_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) !int_n_o |-> $past(sum_int)); // R7
    AST_INT_POLLED:   assert property (@(posedge clk) disable iff (!rst_n) $past(sum_mask) |-> int_n_o); // R7
    AST_APS_POLLED:   assert property (@(posedge clk) disable iff (!rst_n) $past(&aps_mask) |-> aps_int_n_o); // R8
    AST_APS_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) !aps_int_n_o |-> $past(|delta_all[TOT_W-1 -: APS_W])); // R8
endmodule

bind intr_aggregator intr_aggregator_chk #(.TOT_W(TOT_W), .APS_W(APS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_all    (stat_all),
    .delta_all   (delta_all),
    .sum_int     (sum_int),
    .sum_mask    (ctrl_q[intr_agg_pkg::NGRP]),
    .aps_mask    (aps_mask),
    .int_n_o     (int_n_o),
    .aps_int_n_o (aps_int_n_o)
);

// File: tb/intr_aggregator_test.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a behavioural model kept in bench variables.
module intr_aggregator_test;
    localparam int DW = 16;
    localparam int BW [5] = '{9, 2, 6, 3, 2};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic [8:0]  ovh;
    logic [1:0]  ptr;
    logic [5:0]  path;
    logic [2:0]  aux;
    logic [1:0]  aps;
    logic        wr;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        int_n;
    logic        aps_n;

    logic [15:0] st     [5];
    logic [15:0] m_d    [5];
    logic [15:0] m_m    [5];
    logic [15:0] m_prev [5];
    logic [4:0]  m_ctrl;
    logic        m_int_n;
    logic        m_aps_n;
    int          errs;
    int          checks;
    int unsigned seed_val;

    intr_aggregator #(.G0_W(9), .G1_W(2), .G2_W(6), .G3_W(3), .APS_W(2), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ovh_stat_i(ovh), .ptr_stat_i(ptr), .path_stat_i(path),
        .aux_stat_i(aux), .aps_stat_i(aps), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .int_n_o(int_n), .aps_int_n_o(aps_n)
    );

    function automatic logic [15:0] wm(input int b);
        return 16'((32'd1 << BW[b]) - 1);
    endfunction

    function automatic logic hit(input int b);
        return |(m_d[b] & ~m_m[b] & wm(b));
    endfunction

    function automatic logic sum_bit();
        logic s = 1'b0;
        for (int g = 0; g < 4; g++) if (hit(g) && !m_ctrl[g]) s = 1'b1;
        return s;
    endfunction

    function automatic logic [15:0] model_read(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: return m_d[a[1:0]];
            4'd4, 4'd5, 4'd6, 4'd7: return m_m[a[1:0]];
            4'd8:  return m_d[4];
            4'd9:  return m_m[4];
            4'd10: return {11'd0, m_ctrl};
            4'd11: return {10'd0, |m_d[4], sum_bit(), hit(3), hit(2), hit(1), hit(0)};
            default: return 16'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [3:0] a);
        if (a < 4 || a == 8) return "R3";
        if (a < 8 || a == 9 || a == 10) return "R4";
        if (a == 11) return "R5";
        return "R9";
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive_ports();
        ovh = st[0][8:0]; ptr = st[1][1:0]; path = st[2][5:0];
        aux = st[3][2:0]; aps = st[4][1:0];
    endtask

    task automatic model_reset();
        for (int b = 0; b < 5; b++) begin
            m_d[b] = '0; m_m[b] = wm(b); m_prev[b] = st[b] & wm(b);
        end
        m_ctrl = 5'h1F; m_int_n = 1'b1; m_aps_n = 1'b1;
    endtask

    task automatic model_update();
        logic n_int = !(sum_bit() && !m_ctrl[4]);
        logic n_aps = !hit(4);
        for (int b = 0; b < 5; b++) begin
            logic [3:0]  da = (b < 4) ? 4'(b) : 4'd8;
            logic [3:0]  ma = (b < 4) ? 4'(b + 4) : 4'd9;
            logic [15:0] s  = st[b] & wm(b);
            logic [15:0] clr = (wr && addr == da) ? (wdata & wm(b)) : 16'd0;
            m_d[b] = (m_d[b] & ~clr) | (s ^ m_prev[b]);
            m_prev[b] = s;
            if (wr && addr == ma) m_m[b] = wdata & wm(b);
        end
        if (wr && addr == 4'd10) m_ctrl = wdata[4:0];
        m_int_n = n_int;
        m_aps_n = n_aps;
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d, input string tag);
        wr = w; addr = a; wdata = d;
        drive_ports();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R7", "int_n_o", {15'd0, int_n}, {15'd0, m_int_n});
        check("R8", "aps_int_n_o", {15'd0, aps_n}, {15'd0, m_aps_n});
        check(tag, $sformatf("rdata@%0d", a), rdata, model_read(a));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        errs = 0; checks = 0;
        seed_val = $urandom(32'd20240607);
        for (int b = 0; b < 5; b++) st[b] = '0;
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        drive_ports();
        repeat (4) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "int_n_o reset", {15'd0, int_n}, 16'd1);
        check("R1", "aps_int_n_o reset", {15'd0, aps_n}, 16'd1);
        step(1'b0, 4'd4, 16'd0, "R1");
        step(1'b0, 4'd9, 16'd0, "R1");
        step(1'b0, 4'd10, 16'd0, "R1");
        step(1'b0, 4'd0, 16'd0, "R1");

        // R2: rising then falling edge each set the delta
        st[0][3] = 1'b1;
        step(1'b0, 4'd0, 16'd0, "R2");
        check("R2", "delta bit3 after rise", rdata & 16'h0008, 16'h0008);
        // R3: falling edge in the same cycle as a clear keeps the bit
        st[0][3] = 1'b0;
        step(1'b1, 4'd0, 16'h0008, "R3");
        check("R3", "edge wins over clear", rdata & 16'h0008, 16'h0008);
        step(1'b1, 4'd0, 16'h0000, "R3");
        step(1'b1, 4'd0, 16'h0008, "R3");
        check("R3", "clear by write-one", rdata, 16'h0000);

        // R5/R6/R7: unmask source, groups, then summary
        st[1][1] = 1'b1;
        step(1'b1, 4'd5, 16'h0000, "R4");
        step(1'b0, 4'd11, 16'd0, "R5");
        check("R5", "group1 summary", rdata & 16'h0012, 16'h0002);
        step(1'b1, 4'd10, 16'h0010, "R6");
        step(1'b0, 4'd11, 16'd0, "R6");
        check("R6", "global summary under summary mask", rdata & 16'h0010, 16'h0010);
        check("R7", "polled pin stays high", {15'd0, int_n}, 16'd1);
        step(1'b1, 4'd10, 16'h0000, "R7");
        step(1'b0, 4'd11, 16'd0, "R7");
        check("R7", "pin asserted", {15'd0, int_n}, 16'd0);
        step(1'b1, 4'd1, 16'h0002, "R7");
        step(1'b0, 4'd11, 16'd0, "R7");

        // R8: protection bit readable while masked, pin after unmask
        st[4][0] = 1'b1;
        step(1'b0, 4'd11, 16'd0, "R8");
        check("R8", "aps summary while masked", rdata & 16'h0020, 16'h0020);
        step(1'b1, 4'd9, 16'h0000, "R8");
        step(1'b0, 4'd8, 16'd0, "R8");
        check("R8", "aps pin asserted", {15'd0, aps_n}, 16'd0);

        // R9: writes to summary and unmapped addresses ignored
        step(1'b1, 4'd11, 16'hFFFF, "R9");
        step(1'b1, 4'd13, 16'hFFFF, "R9");
        step(1'b1, 4'd15, 16'hFFFF, "R9");
        step(1'b0, 4'd10, 16'd0, "R9");
        step(1'b0, 4'd11, 16'd0, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic        w;
            logic [3:0]  a;
            logic [15:0] d;
            for (int b = 0; b < 5; b++)
                if ($urandom % 4 == 0) st[b] = st[b] ^ 16'(32'd1 << ($urandom % BW[b]));
            w = ($urandom % 3 == 0);
            a = 4'($urandom % 16);
            d = 16'($urandom);
            step(w, a, d, addr_tag(a));
        end

        summary();
        $finish;
    end
endmodule